// File: doc/BRIEF.md
# Link Clock Presence Detector

This block decides whether the bit clock of an external serial audio link is running. A codec attached to the link drives that clock, so a running clock shows that a codec is present. The raw clock is brought into the system clock domain through a three-stage synchronizer. Its rising edges are then counted over fixed windows of system clock cycles. The outcome is kept as an active-low flag in an 8-bit control register. Software controls the detector through two bits in the same register: one enables detection and one holds the flag cleared. A fourth bit chooses which of two protocols, AC'97 or HD audio, drives the shared link pins.

Software reaches the register through a plain synchronous port at byte offset 0x40. The port has an address, write data, a write strobe and registered read data. The control bits and the mode bit keep their values through a warm reset. Only the power-on reset returns them to their initial values. The warm reset restarts only the synchronizer and the edge-counting logic.

Top module: `link_clk_detect`

## Requirements
- R1: After power-on reset the register at offset 0x40 reads 0x02: clear (bit 3), enable (bit 2) and mode (bit 0) are 0, and the flag (bit 1) is 1, meaning no clock detected.
- R2: Read data is registered. `rdata_o` shows the register value one cycle after `addr_i` carries 0x40. Any other address reads 0x00.
- R3: Bits 7:4 always read 0. Writes to bits 7:4 and to the flag in bit 1 have no effect.
- R4: A write to offset 0x40 stores bit 3 (clear), bit 2 (enable) and bit 0 (mode, 0 = AC'97, 1 = HD audio), and reads return them.
- R5: While enable is 1 and clear is 0, a bit clock with at least 4 rising edges in a 256-cycle window drives the flag to 0 at the end of that window.
- R6: A static bit clock, or one with fewer than 4 rising edges in every 256-cycle window, leaves the flag at 1.
- R7: Once the flag is 0 it stays 0 after the bit clock stops, until clear is set.
- R8: While clear is 1, the flag is forced to 1 from the next cycle and held there, even while the bit clock toggles.
- R9: While enable is 0 (and clear is 0), the flag keeps its current value, whether that value is 0 or 1.
- R10: A warm reset leaves bits 3:0 unchanged.
- R11: A power-on reset returns the register to 0x02 from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset, active low, synchronous |
| warm_n_i | input | 1 | Warm reset, active low, synchronous; restarts detection only |
| bclk_i | input | 1 | Raw link bit clock, asynchronous to `clk_i` |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Registered read data |

## Verification
The bench runs the bit clock in four ways: held static, toggling just below the threshold (at most 3 rising edges per window), toggling well above it, and stopping after a detection. A detector that compares its threshold wrongly, or that fails to restart its window, would report a slow clock as present or miss a fast one. The bench sets clear while the clock is running and checks that the flag stays 1. It drops enable in both flag states and checks that the flag stays frozen. Inverting the priority between clear and detection, or letting a disabled detector keep updating, would show up as a wrong flag. Warm and power-on resets are applied from non-default states, so a control bit that is reset on the wrong reset changes the read value.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    localparam int BIT_MODE = 0;
    localparam int BIT_DET  = 1;
    localparam int BIT_EN   = 2;
    localparam int BIT_CLR  = 3;

    // packed MSB first: clr is bit 3, mode is bit 0
    typedef struct packed {
        logic clr;
        logic en;
        logic det_n;
        logic mode;
    } ctrl_t;

    localparam ctrl_t CTRL_POR = '{clr: 1'b0, en: 1'b0, det_n: 1'b1, mode: 1'b0};
endpackage

// File: rtl/lcd_sync.sv
module lcd_sync #(
    parameter int STAGES = 3
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) chain_q <= '0;
        else          chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lcd_activity.sv
module lcd_activity #(
    parameter int WINDOW = 256,
    parameter int THRESH = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    input  logic sync_i,
    output logic hit_o
);
    localparam int WIN_W = $clog2(WINDOW);
    localparam int EC_W  = $clog2(THRESH + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [EC_W-1:0]  THR      = EC_W'(THRESH);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [EC_W-1:0]  edges;
        logic             prev;
        logic             hit;
    } act_t;

    act_t s_d, s_q;
    logic rise;
    logic [EC_W-1:0] edges_inc;

    always_comb begin
        s_d      = s_q;
        s_d.prev = sync_i;
        s_d.hit  = 1'b0;
        rise     = sync_i & ~s_q.prev;
        // saturating edge count
        edges_inc = (rise && (s_q.edges != THR)) ? s_q.edges + EC_W'(1) : s_q.edges;
        if (!run_i) begin
            s_d.win   = '0;
            s_d.edges = '0;
        end else if (s_q.win == WIN_LAST) begin
            s_d.hit   = (edges_inc >= THR);
            s_d.win   = '0;
            s_d.edges = '0;
        end else begin
            s_d.win   = s_q.win + WIN_W'(1);
            s_d.edges = edges_inc;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    assign hit_o = s_q.hit;
endmodule

// File: rtl/lcd_regs.sv
module lcd_regs
    import lcd_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h40
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic              hit_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel;

    always_comb begin
        r_d = r_q;
        sel = (addr_i == REG_OFS);
        if (we_i && sel) begin
            r_d.ctrl.clr  = wdata_i[BIT_CLR];
            r_d.ctrl.en   = wdata_i[BIT_EN];
            r_d.ctrl.mode = wdata_i[BIT_MODE];
        end
        // clear outranks detection
        if (r_q.ctrl.clr)                  r_d.ctrl.det_n = 1'b1;
        else if (r_q.ctrl.en && hit_i)     r_d.ctrl.det_n = 1'b0;
        r_d.rdata = sel ? DATA_W'(r_q.ctrl) : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!por_n_i) r_q <= '{ctrl: CTRL_POR, rdata: '0};
        else          r_q <= r_d;
    end

    assign ctrl_o  = r_q.ctrl;
    assign rdata_o = r_q.rdata;
endmodule

// File: rtl/link_clk_detect.sv
module link_clk_detect
    import lcd_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFS    = 8'h40,
    parameter int                SYNC_STAGE = 3,
    parameter int                WINDOW     = 256,
    parameter int                THRESH     = 4
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic              warm_n_i,
    input  logic              bclk_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic  core_rst_n;
    logic  bclk_sync;
    logic  run_w;
    logic  hit_w;
    ctrl_t ctrl_w;

    assign core_rst_n = por_n_i & warm_n_i;
    assign run_w      = ctrl_w.en & ~ctrl_w.clr;

    lcd_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (core_rst_n),
        .d_i     (bclk_i),
        .q_o     (bclk_sync)
    );

    lcd_activity #(.WINDOW(WINDOW), .THRESH(THRESH)) u_act (
        .clk_i   (clk_i),
        .rst_n_i (core_rst_n),
        .run_i   (run_w),
        .sync_i  (bclk_sync),
        .hit_o   (hit_w)
    );

    lcd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFS(REG_OFS)) u_regs (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .we_i    (we_i),
        .hit_i   (hit_w),
        .ctrl_o  (ctrl_w),
        .rdata_o (rdata_o)
    );
endmodule

// File: rtl/lcd_check.sv
module lcd_check
    import lcd_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h40
) (
    input logic              clk_i,
    input logic              por_n_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] rdata_o,
    input ctrl_t             ctrl,
    input logic              hit
);
    assert_resv_zero_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        rdata_o[DATA_W-1:4] == '0);

    assert_read_lat_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (addr_i == REG_OFS) |=> (rdata_o[3:0] == $past(ctrl)));

    assert_fall_cause_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(ctrl.det_n) |-> $past(hit && ctrl.en && !ctrl.clr));

    assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(ctrl.det_n) |-> $past(ctrl.clr));

    assert_clr_forces_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        ctrl.clr |=> ctrl.det_n);

    assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!ctrl.en && !ctrl.clr) |=> $stable(ctrl.det_n));

    assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !(we_i && addr_i == REG_OFS) |=> $stable(ctrl.mode) && $stable(ctrl.en) && $stable(ctrl.clr));
endmodule

bind link_clk_detect lcd_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFS(REG_OFS)) u_chk (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .ctrl    (ctrl_w),
    .hit     (hit_w)
);

// File: tb/link_clk_detect_test.sv
`timescale 1ns/1ps
module link_clk_detect_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_n = 1'b0;
    logic       bclk = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       we = 1'b0;
    logic [7:0] rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int half = 0;
    bit done = 1'b0;

    logic [7:0] q_exp[$];
    int         q_due[$];
    string      q_tag[$];

    link_clk_detect uut (
        .clk_i(clk), .por_n_i(por_n), .warm_n_i(warm_n), .bclk_i(bclk),
        .addr_i(addr), .wdata_i(wdata), .we_i(we), .rdata_o(rdata)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // bit clock source; half == 0 holds it still
    initial begin
        forever begin
            if (half == 0) @(posedge clk);
            else begin
                repeat (half) @(negedge clk);
                bclk = ~bclk;
            end
        end
    end

    // monitor: compares scoreboard entries when their cycle comes up
    always @(negedge clk) begin
        if (q_exp.size() > 0 && q_due[0] <= cyc) begin
            total++;
            if (rdata !== q_exp[0]) begin
                bad++;
                $display("FAIL %s: rdata=%h expected=%h", q_tag[0], rdata, q_exp[0]);
            end
            void'(q_exp.pop_front());
            void'(q_due.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        q_exp.push_back(exp);
        q_due.push_back(cyc + 1);
        q_tag.push_back(tag);
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        addr = 8'h40; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 8'h00;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: cycles=%0d expected=<60000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        por_n = 1'b1; warm_n = 1'b1;
        read_chk(8'h40, 8'h02, "R1 reset value");
        read_chk(8'h00, 8'h00, "R2 other address");
        read_chk(8'h41, 8'h00, "R2 neighbour address");
        read_chk(8'h40, 8'h02, "R2 back-to-back read");

        // all bits written: reserved dropped, clear holds flag at 1
        write_reg(8'hFF);
        read_chk(8'h40, 8'h0F, "R3 R4 write all ones");

        // enable + mode, bit 1 written 0 is ignored; clock static
        write_reg(8'h05);
        wait_cyc(700);
        read_chk(8'h40, 8'h07, "R6 static clock");

        // slow clock: at most 3 rising edges per window
        half = 60;
        wait_cyc(1300);
        read_chk(8'h40, 8'h07, "R6 slow clock");

        // fast clock
        half = 3;
        wait_cyc(700);
        read_chk(8'h40, 8'h05, "R5 fast clock detected");

        half = 0;
        wait_cyc(700);
        read_chk(8'h40, 8'h05, "R7 flag sticky after stop");

        // clear with clock running
        half = 3;
        write_reg(8'h0D);
        read_chk(8'h40, 8'h0F, "R8 clear forces flag");
        wait_cyc(700);
        read_chk(8'h40, 8'h0F, "R8 clear holds flag");

        // disable with flag at 1, clock running
        write_reg(8'h01);
        wait_cyc(700);
        read_chk(8'h40, 8'h03, "R9 frozen at 1");

        // detect again, then disable with flag at 0
        write_reg(8'h05);
        wait_cyc(700);
        read_chk(8'h40, 8'h05, "R5 re-detect");
        write_reg(8'h01);
        half = 0;
        wait_cyc(700);
        read_chk(8'h40, 8'h01, "R9 frozen at 0");

        // warm reset keeps control bits
        @(negedge clk); warm_n = 1'b0;
        wait_cyc(5);
        warm_n = 1'b1;
        read_chk(8'h40, 8'h01, "R10 warm reset");

        // power-on reset restores default
        @(negedge clk); por_n = 1'b0;
        wait_cyc(5);
        por_n = 1'b1;
        read_chk(8'h40, 8'h02, "R11 power-on reset");

        wait_cyc(5);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule